// File: doc/BRIEF.md
# Pipelined CORDIC Quadrature Oscillator

This block is a numerically controlled oscillator that produces a cosine and sine sample pair. Each accepted input strobe takes the current value of a phase accumulator, sends it into the pipeline, and then advances the accumulator by the tuning word. The output frequency is therefore `tune_word / 2^PHASE_W` of the sample rate. The tuning word can be any fraction of the sample rate, so the ratio between the two rates can be arbitrary. No stored waveform table is needed for this.

The pipeline has three parts:
- A folding stage maps every phase into the half circle around zero.
- `STAGES` rotation-mode CORDIC stages follow. Each stage holds its own arctangent constant, and that constant is computed at elaboration time.
- A final stage rounds, saturates and undoes the fold.

The rotation starts from the reciprocal of the CORDIC gain, so the outputs arrive already at full scale. The in-phase and quadrature values come out of the same rotation. This makes them suitable to drive a complex mixer directly. The only storage in the block is pipeline flip-flops.

Top module: `cordic_nco`

## Requirements
- R1: A synchronous reset clears the output-valid flag on the next clock and zeroes the accumulator. The first sample accepted after reset uses phase 0, so `cos_out` is +32767 and `sin_out` is 0, each within 4 LSB.
- R2: The sample accepted on the n-th strobe after reset uses a phase equal to the sum, modulo 2^32, of the tuning words presented with the earlier strobes. A phase of 2^32 is one full turn, and phase 0 is angle 0.
- R3: A clock cycle with `in_valid` low does not advance the accumulator. The phase of the next accepted sample is unaffected by any number of idle cycles.
- R4: Every accepted strobe produces exactly one output with `out_valid` high, exactly 17 clocks later. A new strobe is accepted on every clock.
- R5: `cos_out` and `sin_out` equal round(32767·cos θ) and round(32767·sin θ) within ±4 LSB, for phases in all four quadrants. θ is 2π·phase/2^32, and the outputs are two's complement.
- R6: The outputs are limited to the symmetric range ±32767, so −32768 is never produced.
- R7: A new tuning word applies from the strobe that carries it, and it sets the phase step to the next sample.
- R8: The internal behaviour has two properties. After folding, the residual angle lies within a quarter turn of zero. After the last stage, the residual angle is no larger than the last arctangent constant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | 32 | Phase increment per accepted sample (2^32 = one turn) |
| in_valid | input | 1 | Accept a sample this cycle and advance the phase |
| cos_out | output | 16 | Signed in-phase sample |
| sin_out | output | 16 | Signed quadrature sample |
| out_valid | output | 1 | `cos_out`/`sin_out` hold a sample |

## Verification
Different internal faults show up at the ports in different ways:
- A corrupted accumulator or a wrong increment shows up as a phase error on every later sample. It persists until reset, and the first wrong pair appears 17 clocks after the faulty strobe.
- A wrong arctangent constant, a wrong shift, or a fold that chooses the wrong quadrant changes the amplitude or angle of the pair itself. This error appears on the very sample that passes through the faulty stage.
- A broken valid delay line shows up as a latency other than 17 clocks, or as an output with no matching input.

The bench compares every output against a cosine and sine computed from its own phase model. It also checks the latency of each output.

// File: rtl/cordic_nco.sv
module cordic_nco #(
  parameter int PHASE_W = 32,
  parameter int OUT_W   = 16,
  parameter int STAGES  = 16,
  parameter int FRAC    = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PHASE_W-1:0]      tune_word,
  input  logic                    in_valid,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out,
  output logic                    out_valid
);

  localparam int  IW      = OUT_W + FRAC + 2;
  localparam int  MAXV    = (1 << (OUT_W-1)) - 1;
  localparam real TWO_PI  = 6.283185307179586;
  localparam real INV_K   = 0.6072529350088813;

  function automatic logic signed [PHASE_W-1:0] atan_units(input int i);
    longint v;
    v = longint'($atan(1.0 / (2.0 ** i)) / TWO_PI * (2.0 ** PHASE_W));
    return v[PHASE_W-1:0];
  endfunction

  localparam logic signed [IW-1:0] X0   = IW'(longint'(INV_K * real'(MAXV) * real'(1 << FRAC)));
  localparam logic signed [IW-1:0] RND  = IW'(1 << (FRAC-1));
  localparam logic signed [IW-1:0] MAXI = IW'(MAXV);
  localparam logic signed [IW-1:0] MINI = -MAXI;
  localparam logic signed [PHASE_W-1:0] ZTOL = atan_units(STAGES-1) + PHASE_W'(64);

  function automatic logic signed [OUT_W-1:0] to_out(input logic signed [IW-1:0] v, input logic flip);
    logic signed [IW-1:0] r;
    r = (v + RND) >>> FRAC;
    if (r > MAXI) r = MAXI;
    if (r < MINI) r = MINI;
    if (flip) r = -r;
    return r[OUT_W-1:0];
  endfunction

  logic [PHASE_W-1:0]        phase_q;
  logic signed [IW-1:0]      xs [0:STAGES];
  logic signed [IW-1:0]      ys [0:STAGES];
  logic signed [PHASE_W-1:0] zs [0:STAGES];
  logic [STAGES:0]           vld;
  logic [STAGES:0]           neg;
  logic                      fold;

  assign fold = phase_q[PHASE_W-1] ^ phase_q[PHASE_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      vld     <= '0;
    end else begin
      vld <= {vld[STAGES-1:0], in_valid};
      if (in_valid) phase_q <= phase_q + tune_word;
    end
  end

  always_ff @(posedge clk) begin
    xs[0] <= X0;
    ys[0] <= '0;
    zs[0] <= fold ? {~phase_q[PHASE_W-1], phase_q[PHASE_W-2:0]} : phase_q;
    neg   <= {neg[STAGES-1:0], fold};
  end

  for (genvar i = 0; i < STAGES; i++) begin : g_rot
    localparam logic signed [PHASE_W-1:0] ANG = atan_units(i);
    always_ff @(posedge clk) begin
      if (zs[i][PHASE_W-1]) begin
        xs[i+1] <= xs[i] + (ys[i] >>> i);
        ys[i+1] <= ys[i] - (xs[i] >>> i);
        zs[i+1] <= zs[i] + ANG;
      end else begin
        xs[i+1] <= xs[i] - (ys[i] >>> i);
        ys[i+1] <= ys[i] + (xs[i] >>> i);
        zs[i+1] <= zs[i] - ANG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= vld[STAGES];
    cos_out <= to_out(xs[STAGES], neg[STAGES]);
    sin_out <= to_out(ys[STAGES], neg[STAGES]);
  end

  localparam longint AMP_LO = longint'(MAXV - 8) * longint'(MAXV - 8);
  localparam longint AMP_HI = longint'(MAXV + 8) * longint'(MAXV + 8);
  longint mag2;
  assign mag2 = longint'(cos_out) * longint'(cos_out) + longint'(sin_out) * longint'(sin_out);

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(phase_q));

  // R5
  amp_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (mag2 >= AMP_LO && mag2 <= AMP_HI));

  // R6
  no_min_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (cos_out != {1'b1, {(OUT_W-1){1'b0}}} && sin_out != {1'b1, {(OUT_W-1){1'b0}}}));

  // R8
  fold_range_chk: assert property (@(posedge clk) disable iff (rst)
    vld[0] |-> (zs[0][PHASE_W-1] == zs[0][PHASE_W-2]));

  // R8
  converge_chk: assert property (@(posedge clk) disable iff (rst)
    vld[STAGES] |-> (zs[STAGES] <= ZTOL && zs[STAGES] >= -ZTOL));

endmodule

// File: tb/tb_cordic_nco.sv
module tb_cordic_nco;
  localparam int LAT = 17;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] tune_word = '0;
  logic in_valid = 1'b0;
  logic signed [15:0] cos_out, sin_out;
  logic out_valid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] exp_phase = '0;
  logic [31:0] ph_q [$];
  int          st_q [$];
  string       tag = "R1";

  cordic_nco dut (.clk(clk), .rst(rst), .tune_word(tune_word), .in_valid(in_valid),
                  .cos_out(cos_out), .sin_out(sin_out), .out_valid(out_valid));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (ph_q.size() == 0) begin
        check(1'b0, "R4", "unexpected out_valid", 1, 0);
      end else begin
        logic [31:0] ph;
        int st, ec, es;
        real a;
        ph = ph_q.pop_front();
        st = st_q.pop_front();
        a  = TWO_PI * real'(ph) / 4294967296.0;
        ec = int'(32767.0 * $cos(a));
        es = int'(32767.0 * $sin(a));
        check(cyc - st == LAT, "R4", "latency", cyc - st, LAT);
        check(int'(cos_out) - ec <= 4 && ec - int'(cos_out) <= 4, tag, "cos R5", int'(cos_out), ec);
        check(int'(sin_out) - es <= 4 && es - int'(sin_out) <= 4, tag, "sin R5", int'(sin_out), es);
        check(cos_out != -16'sd32768 && sin_out != -16'sd32768, "R6", "min code", int'(cos_out), -32767);
      end
    end
  end

  task automatic send(input logic [31:0] tw);
    @(negedge clk);
    tune_word = tw;
    in_valid  = 1'b1;
    ph_q.push_back(exp_phase);
    st_q.push_back(cyc + 1);
    exp_phase = exp_phase + tw;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain(input string req);
    idle(LAT + 4);
    check(ph_q.size() == 0, req, "R4 missing outputs", ph_q.size(), 0);
  endtask

  task automatic t_reset_state;
    tag = "R1";
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    send(32'd12345);
    drain("R1");
  endtask

  task automatic t_quadrants;
    tag = "R2";
    for (int k = 0; k < 9; k++) send(32'h4000_0000);
    drain("R2");
    tag = "R5";
    for (int k = 0; k < 16; k++) send(32'h1000_0000 + 32'd777);
    drain("R5");
  endtask

  task automatic t_stream;
    tag = "R4";
    for (int k = 0; k < 40; k++) send(32'd598016237);
    drain("R4");
  endtask

  task automatic t_gaps;
    tag = "R3";
    for (int k = 0; k < 12; k++) begin
      send(32'd123456789);
      idle(k % 4);
    end
    drain("R3");
  endtask

  task automatic t_retune;
    tag = "R7";
    for (int k = 0; k < 6; k++) send(32'd40000000);
    for (int k = 0; k < 6; k++) send(32'hDEAD_BEEF);
    for (int k = 0; k < 6; k++) send(32'h8000_0000);
    drain("R7");
  endtask

  task automatic t_mid_reset;
    tag = "R1";
    for (int k = 0; k < 10; k++) send(32'd300000000);
    @(posedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    ph_q.delete();
    st_q.delete();
    exp_phase = '0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "valid after reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(LAT + 4);
    send(32'd5);
    drain("R1");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_quadrants();
        t_stream();
        t_gaps();
        t_retune();
        t_mid_reset();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule